// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches a six-pin general-purpose input port. It raises a sticky change flag whenever an enabled pin differs from a snapshot of the port. The snapshot is refreshed only when software reads or writes the port. It is not refreshed from the previous clock sample. Because of this, the flag keeps re-asserting until the interrupt handler touches the port and then clears the flag. Raw pin levels pass through a two-stage synchronizer. Both the comparison and the snapshot work on the synchronized values.

Software sees three things: a per-pin enable register, strobes for port access and flag clear, and a readback of the port. Two mode inputs suppress some enable bits. While a crystal-class oscillator mode is selected, enables 5 and 4 read as zero and have no effect. While a wake-up-receiver mode is active and the device sleeps, enable 3 has no effect. The flag drives a wake output directly. It also drives an interrupt request, which is gated by the global enable.

Nothing in this block streams data, so there is no valid/ready handshake. Every pin is a plain level or a single-cycle strobe, and no strobe is ever back-pressured.

Top module: `pin_change_irq`

## Requirements
- R1: A pulse on `en_wr` stores `wr_data[5:0]` into the six enable bits, bit n enabling pin n. `en_rdata[7:6]` always reads 0.
- R2: While `por_n` is low, the enable bits, the snapshot, the synchronizer and the flag are all cleared. After release, `chg_flag`, `irq`, `wake`, `en_rdata` and `port_rdata` are 0.
- R3: A pin change passes two synchronizer flops. The flag rises on the third rising edge after the change, and not on the second.
- R4: The flag sets when at least one enabled pin's synchronized level differs from its snapshot bit. Differences on disabled pins never set it.
- R5: While a mismatch remains, a `flag_clr` pulse leaves the flag at 1, because setting wins over clearing.
- R6: A pulse on `port_rd` or `port_wr` loads the snapshot from the synchronized pins. After that, `flag_clr` clears the flag, and it stays clear. `port_rdata` shows the synchronized pins.
- R7: In a cycle that has a port access, a mismatch does not set the flag, because the snapshot load takes priority.
- R8: A low `warm_rst_n` clears only the flag. The enables and the snapshot are kept, so a mismatch that persists sets the flag again on the first edge after release.
- R9: `wake` follows the flag whatever `gie` is. `irq` is the flag gated by `gie`.
- R10: While `osc_xtal` is 1, enable bits 5 and 4 read as 0 and are ignored. Their stored values take effect again once `osc_xtal` returns to 0.
- R11: Enable bit 3 is ignored only while `wur_mode` and `sleep` are both 1. Either one alone leaves it active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm (master-clear / brown-out) reset, synchronous, active low |
| pin_i | input | 6 | Asynchronous port pin levels |
| en_wr | input | 1 | Write strobe for the enable register |
| wr_data | input | 8 | Write data for the enable register |
| en_rdata | output | 8 | Effective enable register readback |
| port_rd | input | 1 | Port read strobe |
| port_wr | input | 1 | Port write strobe |
| port_rdata | output | 6 | Synchronized pin levels |
| flag_clr | input | 1 | Software clear of the change flag |
| gie | input | 1 | Global interrupt enable |
| osc_xtal | input | 1 | Crystal-class oscillator mode selected |
| wur_mode | input | 1 | Wake-up-receiver mode active |
| sleep | input | 1 | Device is asleep |
| chg_flag | output | 1 | Change interrupt flag |
| irq | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Sleep wake-up request, combinational from the flag |

## Verification
The bench sets a port access in the exact cycle in which a synchronized change first appears. A design that evaluated the mismatch before loading the snapshot would wrongly set the flag there. It pulses the clear while a mismatch remains: a clear-wins design would drop the flag and lose the event. It applies a warm reset with a mismatch pending. A design that reset the snapshot or the enables would fail to set the flag again. It also toggles the oscillator and sleep modes around a pending change, and checks the exact latency through the synchronizer. The masked enables must come back to life, and a flag that appears one cycle early or late is reported.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int PCD_PINS   = 6;
  localparam int PCD_REG_W  = 8;
  localparam int PCD_SYNC   = 2;

  // Bit masks of enables that a mode input can suppress
  localparam logic [PCD_PINS-1:0] PCD_OSC_MASK = 6'b110000;
  localparam logic [PCD_PINS-1:0] PCD_WUR_MASK = 6'b001000;

  typedef struct packed {
    logic osc_xtal;
    logic wur_sleep;
  } pcd_mode_t;

  function automatic logic pcd_any_diff(input logic [PCD_PINS-1:0] a,
                                        input logic [PCD_PINS-1:0] b,
                                        input logic [PCD_PINS-1:0] en);
    return |((a ^ b) & en);
  endfunction
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcd_enable_reg.sv
module pcd_enable_reg
  import pcd_pkg::*;
#(
  parameter int             W        = PCD_PINS,
  parameter int             RW       = PCD_REG_W,
  parameter logic [W-1:0]   OSC_MASK = PCD_OSC_MASK,
  parameter logic [W-1:0]   WUR_MASK = PCD_WUR_MASK
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr,
  input  logic [RW-1:0] wdata,
  input  pcd_mode_t     mode,
  output logic [W-1:0]  en_eff,
  output logic [RW-1:0] rdata
);
  localparam int PAD = RW - W;

  logic [W-1:0] en_q;
  logic [W-1:0] osc_kill;
  logic [W-1:0] wur_kill;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)  en_q <= '0;
    else if (wr) en_q <= wdata[W-1:0];
  end

  assign osc_kill = mode.osc_xtal  ? OSC_MASK : '0;
  assign wur_kill = mode.wur_sleep ? WUR_MASK : '0;
  assign en_eff   = en_q & ~osc_kill & ~wur_kill;
  assign rdata    = {{PAD{1'b0}}, en_q & ~osc_kill};

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    rdata[RW-1:W] == '0);                                           // R1
  AST_OSC_HIDE: assert property (@(posedge clk) disable iff (!por_n)
    mode.osc_xtal |-> ((rdata[W-1:0] & OSC_MASK) == '0));          // R10
  AST_WR_STORE: assert property (@(posedge clk) disable iff (!por_n)
    (wr && !mode.osc_xtal) |=> (mode.osc_xtal || rdata[W-1:0] == $past(wdata[W-1:0]))); // R1
endmodule

// File: rtl/pcd_detect.sv
module pcd_detect
  import pcd_pkg::*;
#(
  parameter int W = PCD_PINS
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         warm_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] en_eff,
  input  logic         access,
  input  logic         flag_clr,
  output logic         flag,
  output logic         mismatch
);
  logic [W-1:0] snap_q;
  logic         flag_q;
  logic         set_req;

  // Snapshot survives warm reset; only power-on clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      snap_q <= '0;
    else if (access) snap_q <= pin_sync;
  end

  assign mismatch = pcd_any_diff(pin_sync, snap_q, en_eff);
  // Snapshot load wins over mismatch evaluation in the same cycle
  assign set_req  = mismatch && !access;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         flag_q <= 1'b0;
    else if (!warm_n)   flag_q <= 1'b0;
    else if (set_req)   flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  assign flag = flag_q;

  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    access |=> !mismatch || $changed(pin_sync));                        // R6
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (mismatch && !access) |=> flag);                                    // R5
  AST_ACCESS_NO_SET: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (!flag && access) |=> !flag);                                       // R7
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (flag_clr && !mismatch) |=> !flag);                                 // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (!flag && !mismatch) |=> !flag);                                    // R4
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcd_pkg::*;
#(
  parameter int           PINS     = PCD_PINS,
  parameter int           REG_W    = PCD_REG_W,
  parameter int           SYNC     = PCD_SYNC,
  parameter logic [PINS-1:0] OSC_MASK = PCD_OSC_MASK,
  parameter logic [PINS-1:0] WUR_MASK = PCD_WUR_MASK
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             warm_rst_n,
  input  logic [PINS-1:0]  pin_i,
  input  logic             en_wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] en_rdata,
  input  logic             port_rd,
  input  logic             port_wr,
  output logic [PINS-1:0]  port_rdata,
  input  logic             flag_clr,
  input  logic             gie,
  input  logic             osc_xtal,
  input  logic             wur_mode,
  input  logic             sleep,
  output logic             chg_flag,
  output logic             irq,
  output logic             wake
);
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] en_eff;
  logic            mismatch;
  logic            access;
  pcd_mode_t       mode;

  assign mode.osc_xtal  = osc_xtal;
  assign mode.wur_sleep = wur_mode & sleep;
  assign access         = port_rd | port_wr;

  pcd_sync #(.W(PINS), .STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (pin_i),
    .q     (pin_sync)
  );

  pcd_enable_reg #(.W(PINS), .RW(REG_W), .OSC_MASK(OSC_MASK), .WUR_MASK(WUR_MASK)) u_en (
    .clk    (clk),
    .por_n  (por_n),
    .wr     (en_wr),
    .wdata  (wr_data),
    .mode   (mode),
    .en_eff (en_eff),
    .rdata  (en_rdata)
  );

  pcd_detect #(.W(PINS)) u_det (
    .clk      (clk),
    .por_n    (por_n),
    .warm_n   (warm_rst_n),
    .pin_sync (pin_sync),
    .en_eff   (en_eff),
    .access   (access),
    .flag_clr (flag_clr),
    .flag     (chg_flag),
    .mismatch (mismatch)
  );

  assign port_rdata = pin_sync;
  assign wake       = chg_flag;
  assign irq        = chg_flag & gie;

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> (gie && wake));                                             // R9
  AST_WARM_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |=> !chg_flag);                                         // R8
  AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
    (chg_flag && gie) |-> irq);                                         // R9
endmodule

// File: tb/pin_change_irq_test.sv
module pin_change_irq_test;
  logic       clk = 1'b0;
  logic       por_n, warm_rst_n;
  logic [5:0] pin_i;
  logic       en_wr;
  logic [7:0] wr_data;
  logic [7:0] en_rdata;
  logic       port_rd, port_wr;
  logic [5:0] port_rdata;
  logic       flag_clr, gie, osc_xtal, wur_mode, sleep;
  logic       chg_flag, irq, wake;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pin_change_irq uut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .pin_i(pin_i),
    .en_wr(en_wr), .wr_data(wr_data), .en_rdata(en_rdata),
    .port_rd(port_rd), .port_wr(port_wr), .port_rdata(port_rdata),
    .flag_clr(flag_clr), .gie(gie), .osc_xtal(osc_xtal), .wur_mode(wur_mode),
    .sleep(sleep), .chg_flag(chg_flag), .irq(irq), .wake(wake)
  );

  // {enable, snapshot pins, new pins}
  localparam logic [17:0] VEC [8] = '{
    {6'h3F, 6'h00, 6'h01},
    {6'h3F, 6'h15, 6'h15},
    {6'h01, 6'h00, 6'h3E},
    {6'h20, 6'h00, 6'h20},
    {6'h00, 6'h3F, 6'h00},
    {6'h0A, 6'h2A, 6'h20},
    {6'h14, 6'h2A, 6'h2B},
    {6'h3F, 6'h3F, 6'h00}
  };

  task automatic nx(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_en(input logic [5:0] v);
    en_wr = 1'b1; wr_data = {2'b00, v};
    nx(1);
    en_wr = 1'b0;
  endtask

  task automatic align();
    port_rd = 1'b1; flag_clr = 1'b1;
    nx(1);
    port_rd = 1'b0; flag_clr = 1'b0;
    nx(1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    por_n = 1'b0; warm_rst_n = 1'b1; pin_i = '0; en_wr = 1'b0; wr_data = '0;
    port_rd = 1'b0; port_wr = 1'b0; flag_clr = 1'b0; gie = 1'b0;
    osc_xtal = 1'b0; wur_mode = 1'b0; sleep = 1'b0;
    nx(3);
    por_n = 1'b1;
    nx(1);
    chk("R2 flag", {7'd0, chg_flag}, 8'd0);
    chk("R2 irq/wake", {6'd0, irq, wake}, 8'd0);
    chk("R2 enables", en_rdata, 8'd0);
    chk("R2 port", {2'b0, port_rdata}, 8'd0);

    // R4 vector table
    for (int i = 0; i < 8; i++) begin
      logic [5:0] en, p0, p1;
      logic exp;
      {en, p0, p1} = VEC[i];
      exp = |((p0 ^ p1) & en);
      pin_i = p0;
      write_en(en);
      nx(3);
      align();
      pin_i = p1;
      nx(4);
      chk($sformatf("R4 vector %0d", i), {7'd0, chg_flag}, {7'd0, exp});
    end

    // R1 unimplemented bits
    write_en(6'h3F);
    en_wr = 1'b1; wr_data = 8'hFF; nx(1); en_wr = 1'b0;
    chk("R1 readback", en_rdata, 8'h3F);

    // R3 synchronizer latency
    write_en(6'h01);
    pin_i = 6'h00; nx(3); align();
    pin_i = 6'h01;
    nx(2);
    chk("R3 not after two edges", {7'd0, chg_flag}, 8'd0);
    nx(1);
    chk("R3 set on third edge", {7'd0, chg_flag}, 8'd1);

    // R5 clear loses to live mismatch
    flag_clr = 1'b1; nx(1); flag_clr = 1'b0;
    chk("R5 flag held", {7'd0, chg_flag}, 8'd1);

    // R9 gating
    gie = 1'b0;
    #1 chk("R9 irq off wake on", {6'd0, irq, wake}, 8'd1);
    gie = 1'b1;
    #1 chk("R9 irq on", {6'd0, irq, wake}, 8'd3);
    gie = 1'b0;

    // R6 read reloads snapshot then clear works
    port_rd = 1'b1; nx(1); port_rd = 1'b0;
    chk("R6 flag kept after read", {7'd0, chg_flag}, 8'd1);
    chk("R6 port readback", {2'b0, port_rdata}, 8'h01);
    flag_clr = 1'b1; nx(1); flag_clr = 1'b0;
    chk("R6 cleared", {7'd0, chg_flag}, 8'd0);
    nx(3);
    chk("R6 stays clear", {7'd0, chg_flag}, 8'd0);

    // R6 write strobe path
    pin_i = 6'h00; nx(4);
    chk("R6 mismatch before write", {7'd0, chg_flag}, 8'd1);
    port_wr = 1'b1; nx(1); port_wr = 1'b0;
    flag_clr = 1'b1; nx(1); flag_clr = 1'b0;
    nx(2);
    chk("R6 write ends mismatch", {7'd0, chg_flag}, 8'd0);

    // R8 warm reset keeps snapshot and enables
    pin_i = 6'h01; nx(4);
    chk("R8 pre flag", {7'd0, chg_flag}, 8'd1);
    warm_rst_n = 1'b0; nx(1);
    chk("R8 flag cleared", {7'd0, chg_flag}, 8'd0);
    chk("R8 enables kept", en_rdata, 8'h01);
    warm_rst_n = 1'b1; nx(1);
    chk("R8 flag re-set", {7'd0, chg_flag}, 8'd1);
    align();

    // R7 access in the first mismatch cycle
    pin_i = 6'h00;
    nx(2);
    port_rd = 1'b1; nx(1); port_rd = 1'b0;
    chk("R7 no set at access", {7'd0, chg_flag}, 8'd0);
    nx(3);
    chk("R7 still clear", {7'd0, chg_flag}, 8'd0);

    // R10 oscillator mode masks bits 5:4
    write_en(6'h30);
    osc_xtal = 1'b1;
    #1 chk("R10 reads zero", en_rdata, 8'h00);
    pin_i = 6'h30; nx(4);
    chk("R10 no effect", {7'd0, chg_flag}, 8'd0);
    osc_xtal = 1'b0; nx(1);
    chk("R10 restored flag", {7'd0, chg_flag}, 8'd1);
    chk("R10 restored read", en_rdata, 8'h30);

    // R11 wake-up-receiver plus sleep masks bit 3
    write_en(6'h08);
    align();
    wur_mode = 1'b1; sleep = 1'b1;
    pin_i = 6'h38; nx(4);
    chk("R11 ignored asleep", {7'd0, chg_flag}, 8'd0);
    sleep = 1'b0; nx(1);
    chk("R11 awake active", {7'd0, chg_flag}, 8'd1);
    align();
    wur_mode = 1'b0; sleep = 1'b1;
    pin_i = 6'h30; nx(4);
    chk("R11 sleep alone active", {7'd0, chg_flag}, 8'd1);

    summary();
    $finish;
  end
endmodule